// File: doc/BRIEF.md
# Cache Block Refill Sequencer

This block brings one whole cache line in from main memory after a miss and reports how many clock cycles the refill took. A miss is given to it as a block address with a request strobe. The sequencer puts that address on the memory side for one cycle, waits out the fixed memory access time, and then moves the line across the memory bus one beat at a time into a line buffer. When the last beat has been captured it raises a one-cycle completion pulse with the assembled line and the cycle count on its outputs.

One parameter selects how main memory is organised. The narrow option has a one-word memory and a one-word bus. The wide option has a four-word memory and a four-word bus. The interleaved option has four one-word banks that are read in parallel and then share a one-word bus. With the default sizes (16-word line, 10-cycle access, 1-cycle transfer, 1-cycle address phase) the refill costs 177, 45 or 57 cycles. This is fixed for each option, so the cache around the block knows the stall length in advance.

The memory side is deliberately simple. The sequencer names the word index of each transfer, and the memory answers on `mem_rdata` in that same cycle.

Top module: `refill_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `mem_addr_valid` and `mem_xfer` are all low.
- R2: A request is accepted at a rising edge where `miss_valid` is high and `busy` is low. `busy` is high in every cycle from the one after acceptance up to and including the last transfer cycle, and low in the cycle where `done` is high.
- R3: In the first cycle after acceptance, and only then, `mem_addr_valid` is high and `mem_addr` carries the accepted block address.
- R4: Narrow organisation (ORG = ORG_NARROW): `done` is high for exactly one cycle, namely 177 rising edges after the accepting edge (1 + 16×10 + 16×1).
- R5: Wide organisation (ORG = ORG_WIDE): `done` is high for exactly one cycle, 45 rising edges after the accepting edge (1 + 4×10 + 4×1).
- R6: Interleaved organisation (ORG = ORG_INTERLEAVED): `done` is high for exactly one cycle, 57 rising edges after the accepting edge (1 + 4×10 + 16×1).
- R7: Transfers are named in ascending word order starting from 0 on `mem_word_idx`. The index steps by 1 in the narrow and interleaved options. It steps by 4 in the wide option, where lane k of `mem_rdata` (bits k×WORD_W upward) carries word `mem_word_idx`+k.
- R8: In the interleaved option, each 10-cycle access round is followed by four consecutive one-word transfers. The bank serving a transfer is given by `mem_word_idx[1:0]`, so word i comes from bank i mod 4.
- R9: The data on `mem_rdata` in a transfer cycle is captured at the end of that cycle. When `done` is high, word i of the line sits at `line_data[i*WORD_W +: WORD_W]`.
- R10: A request raised while `busy` is high is ignored. It starts no address phase, produces no transfer and no `done`, and does not change the line that is delivered.
- R11: When `done` is high, `refill_cycles` equals the refill penalty of the selected organisation (177, 45 or 57).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | ADDR_W | Block address of the missing line |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle completion pulse |
| line_data | output | LINE_WORDS×WORD_W | Assembled line, word 0 in the low bits |
| refill_cycles | output | CNT_W | Cycles taken by the latest refill |
| mem_addr_valid | output | 1 | Address phase strobe to memory |
| mem_addr | output | ADDR_W | Block address sent to memory |
| mem_xfer | output | 1 | A bus transfer takes place this cycle |
| mem_word_idx | output | IDX_W | Index of the first word moved by this transfer |
| mem_rdata | input | BUS_W | Memory data: 4×WORD_W in the wide option, WORD_W otherwise |

## Verification
The address phase is due in the cycle right after the accepting edge. Transfers start 11 cycles after acceptance and recur with the spacing of the selected organisation. Completion, the full line and the cycle count are due exactly 177, 45 or 57 edges after acceptance. The bench records the edge number at which each request was accepted and queues the due edge for the request. Its monitor samples on the falling edge and compares each output only at its due edge: the address phase at acceptance plus one, the transfer index against a running expectation, and done, line and count at the due edge. The same monitor requires quiet outputs whenever no request is outstanding, which catches any start caused by an ignored request.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW      = 2'd0,
    ORG_WIDE        = 2'd1,
    ORG_INTERLEAVED = 2'd2
  } mem_org_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } refill_state_e;

  // words delivered per bus beat
  function automatic int beat_words(mem_org_e org, int lanes);
    return (org == ORG_WIDE) ? lanes : 1;
  endfunction

  // words fetched per memory access round
  function automatic int round_words(mem_org_e org, int lanes);
    return (org == ORG_NARROW) ? 1 : lanes;
  endfunction

  function automatic int penalty(mem_org_e org, int line_words, int lanes,
                                 int access_cyc);
    int rounds;
    int beats_per_round;
    rounds          = line_words / round_words(org, lanes);
    beats_per_round = round_words(org, lanes) / beat_words(org, lanes);
    return 1 + rounds * (access_cyc + beats_per_round);
  endfunction

endpackage

// File: rtl/refill_fsm.sv
module refill_fsm #(
  parameter int ADDR_W      = 32,
  parameter int LINE_WORDS  = 16,
  parameter int BEAT_WORDS  = 1,
  parameter int BEATS_RND   = 1,
  parameter int ACCESS_CYC  = 10,
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int WAIT_W     = $clog2(ACCESS_CYC),
  localparam int BC_W       = (BEATS_RND > 1) ? $clog2(BEATS_RND) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_xfer,
  output logic [IDX_W-1:0]  mem_word_idx
);
  import refill_pkg::*;

  refill_state_e     state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [BC_W-1:0]   beat_cnt;
  logic [IDX_W-1:0]  idx_q;
  logic              last_beat;
  logic              round_end;
  logic              accept;

  assign busy         = (state != ST_IDLE);
  assign mem_xfer     = (state == ST_XFER);
  assign mem_word_idx = idx_q;
  assign accept       = miss_valid && (state == ST_IDLE);
  assign last_beat    = (idx_q == IDX_W'(LINE_WORDS - BEAT_WORDS));
  assign round_end    = (beat_cnt == BC_W'(BEATS_RND - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      done           <= 1'b0;
      mem_addr_valid <= 1'b0;
      mem_addr       <= '0;
      wait_cnt       <= '0;
      beat_cnt       <= '0;
      idx_q          <= '0;
    end else begin
      done           <= 1'b0;
      mem_addr_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state          <= ST_ADDR;
            mem_addr       <= miss_addr;
            mem_addr_valid <= 1'b1;
            idx_q          <= '0;
          end
        end
        ST_ADDR: begin
          state    <= ST_ACCESS;
          wait_cnt <= '0;
        end
        ST_ACCESS: begin
          if (wait_cnt == WAIT_W'(ACCESS_CYC - 1)) begin
            state    <= ST_XFER;
            beat_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_XFER: begin
          idx_q <= idx_q + IDX_W'(BEAT_WORDS);
          if (last_beat) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (round_end) begin
            state    <= ST_ACCESS;
            wait_cnt <= '0;
          end else begin
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted request makes the block busy in the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !busy) |=> busy);

  // R2: completion is reported with busy already released
  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3: acceptance is followed by exactly one address-phase cycle
  p_addr_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !busy) |=> mem_addr_valid);

  p_addr_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_addr_valid |=> !mem_addr_valid);

  // R4: completion lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: transfers only during a refill
  p_xfer_in_refill_r7: assert property (@(posedge clk) disable iff (rst)
    mem_xfer |-> busy);

  // R10: the latched block address does not move while a refill runs
  p_addr_held_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_addr_valid) |=> $stable(mem_addr));

endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int BEAT_WORDS = 1,
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int BUS_W     = BEAT_WORDS * WORD_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         beat,
  input  logic [IDX_W-1:0]             beat_idx,
  input  logic [BUS_W-1:0]             beat_data,
  output logic [LINE_WORDS*WORD_W-1:0] line
);

  logic [WORD_W-1:0] words [LINE_WORDS];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    localparam int SLOT = w / BEAT_WORDS;
    localparam int LANE = w % BEAT_WORDS;
    logic hit;
    assign hit = beat && ((int'(beat_idx) / BEAT_WORDS) == SLOT);
    always_ff @(posedge clk) begin
      if (hit) words[w] <= beat_data[LANE*WORD_W +: WORD_W];
    end
    assign line[w*WORD_W +: WORD_W] = words[w];
  end

  // R7: every beat starts on a beat-aligned word index
  p_beat_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    beat |-> ((int'(beat_idx) % BEAT_WORDS) == 0));

endmodule

// File: rtl/refill_seq.sv
module refill_seq #(
  parameter refill_pkg::mem_org_e ORG = refill_pkg::ORG_NARROW,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int LANES      = 4,
  parameter int ACCESS_CYC = 10,
  localparam int BEAT_WORDS = refill_pkg::beat_words(ORG, LANES),
  localparam int BEATS_RND  = refill_pkg::round_words(ORG, LANES) / BEAT_WORDS,
  localparam int PENALTY    = refill_pkg::penalty(ORG, LINE_WORDS, LANES, ACCESS_CYC),
  localparam int CNT_W      = $clog2(PENALTY + 1),
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int BUS_W      = BEAT_WORDS * WORD_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         miss_valid,
  input  logic [ADDR_W-1:0]            miss_addr,
  output logic                         busy,
  output logic                         done,
  output logic [LINE_WORDS*WORD_W-1:0] line_data,
  output logic [CNT_W-1:0]             refill_cycles,
  output logic                         mem_addr_valid,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_xfer,
  output logic [IDX_W-1:0]             mem_word_idx,
  input  logic [BUS_W-1:0]             mem_rdata
);

  refill_fsm #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS),
    .BEAT_WORDS (BEAT_WORDS),
    .BEATS_RND  (BEATS_RND),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .miss_valid     (miss_valid),
    .miss_addr      (miss_addr),
    .busy           (busy),
    .done           (done),
    .mem_addr_valid (mem_addr_valid),
    .mem_addr       (mem_addr),
    .mem_xfer       (mem_xfer),
    .mem_word_idx   (mem_word_idx)
  );

  refill_linebuf #(
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .BEAT_WORDS (BEAT_WORDS)
  ) u_linebuf (
    .clk       (clk),
    .rst       (rst),
    .beat      (mem_xfer),
    .beat_idx  (mem_word_idx),
    .beat_data (mem_rdata),
    .line      (line_data)
  );

  // refill cycle counter: cleared on acceptance, advanced while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      refill_cycles <= '0;
    end else if (miss_valid && !busy) begin
      refill_cycles <= '0;
    end else if (busy) begin
      refill_cycles <= refill_cycles + 1'b1;
    end
  end

  // R11: count at completion equals the organisation's penalty
  p_cycles_at_done_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (refill_cycles == CNT_W'(PENALTY)));

endmodule

// File: tb/refill_seq_bench.sv
module refill_seq_harness #(
  parameter refill_pkg::mem_org_e ORG = refill_pkg::ORG_NARROW,
  parameter int PEN  = 177,
  parameter int BEAT = 1,
  parameter string PTAG = "R4"
) (
  input  logic        clk,
  input  logic        rst,
  input  int          cyc,
  output logic        finished,
  output int          checks,
  output int          errors
);
  localparam int LW = 16;
  localparam int BW = BEAT * 32;

  logic           miss_valid;
  logic [31:0]    miss_addr;
  logic           busy, done, mem_addr_valid, mem_xfer;
  logic [LW*32-1:0] line_data;
  logic [$clog2(PEN+1)-1:0] refill_cycles;
  logic [31:0]    mem_addr;
  logic [3:0]     mem_word_idx;
  logic [BW-1:0]  mem_rdata;
  logic [31:0]    mem_blk;

  int          due_q[$];
  logic [31:0] addr_q[$];
  int          exp_idx;

  refill_seq #(.ORG(ORG)) u_refill_seq (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .busy(busy), .done(done), .line_data(line_data),
    .refill_cycles(refill_cycles), .mem_addr_valid(mem_addr_valid),
    .mem_addr(mem_addr), .mem_xfer(mem_xfer), .mem_word_idx(mem_word_idx),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] fdat(logic [31:0] a, int i);
    return (a * 32'h9E3779B1) ^ {i[7:0], 24'h0} ^ (32'(i) * 32'h101);
  endfunction

  // memory model: block latched in the address phase, data answered in the transfer cycle
  always @(posedge clk) if (mem_addr_valid) mem_blk <= mem_addr;

  always_comb begin
    mem_rdata = '0;
    if (ORG == refill_pkg::ORG_INTERLEAVED) begin
      // bank = idx[1:0], row = idx[3:2]; bank b row r holds word 4r+b
      mem_rdata[31:0] = fdat(mem_blk, int'(mem_word_idx[3:2]) * 4 + int'(mem_word_idx[1:0]));
    end else begin
      for (int k = 0; k < BEAT; k++)
        mem_rdata[k*32 +: 32] = fdat(mem_blk, int'(mem_word_idx) + k);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL org=%0d %s: actual %0h expected %0h", ORG, tag, act, exp);
    end
  endtask

  // driver: issue a request, wait for its acceptance, push the due edge
  task automatic issue(input logic [31:0] a, input bit hold);
    bit was_busy;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    forever begin
      was_busy = busy;
      @(posedge clk);
      #1;
      if (!was_busy) break;
    end
    due_q.push_back(cyc + PEN);
    addr_q.push_back(a);
    if (!hold) begin
      @(negedge clk);
      miss_valid = 1'b0;
    end
  endtask

  task automatic drain();
    while (due_q.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      if (due_q.size() > 0) begin
        int due;
        int acc;
        due = due_q[0];
        acc = due - PEN;
        if (cyc == acc) begin
          check(mem_addr_valid && (mem_addr == addr_q[0]), "R3 address phase",
                {31'b0, mem_addr_valid, mem_addr}, {32'h1, addr_q[0]});
          exp_idx = 0;
        end else if (cyc > acc) begin
          check(!mem_addr_valid, "R3 single address cycle", 64'(mem_addr_valid), 64'd0);
        end
        if (cyc >= acc && cyc < due) begin
          check(busy && !done, "R2 busy during refill", {62'b0, busy, done}, 64'd2);
          if (mem_xfer) begin
            check(int'(mem_word_idx) == exp_idx,
                  (ORG == refill_pkg::ORG_INTERLEAVED) ? "R8 bank order" : "R7 word order",
                  64'(mem_word_idx), 64'(exp_idx));
            exp_idx += BEAT;
          end
        end
        if (cyc == due) begin
          bit line_ok;
          line_ok = 1'b1;
          check(done && !busy, {PTAG, " done at penalty"}, {62'b0, done, busy}, 64'd2);
          check(64'(refill_cycles) == 64'(PEN), "R11 cycle count",
                64'(refill_cycles), 64'(PEN));
          check(exp_idx == LW, "R7 transfer count", 64'(exp_idx), 64'(LW));
          for (int i = 0; i < LW; i++) begin
            if (line_data[i*32 +: 32] != fdat(addr_q[0], i)) begin
              line_ok = 1'b0;
              check(1'b0, "R9 line word", 64'(line_data[i*32 +: 32]),
                    64'(fdat(addr_q[0], i)));
            end
          end
          if (line_ok) check(1'b1, "R9 line", 64'd0, 64'd0);
          void'(due_q.pop_front());
          void'(addr_q.pop_front());
        end
      end else begin
        // R10: nothing outstanding, so no refill activity may appear
        check(!done && !mem_xfer && !mem_addr_valid, "R10 idle outputs quiet",
              {61'b0, done, mem_xfer, mem_addr_valid}, 64'd0);
      end
    end
  end

  initial begin
    finished   = 1'b0;
    checks     = 0;
    errors     = 0;
    exp_idx    = 0;
    miss_valid = 1'b0;
    miss_addr  = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !mem_addr_valid && !mem_xfer, "R1 reset state",
          {60'b0, busy, done, mem_addr_valid, mem_xfer}, 64'd0);
    // single refill
    issue(32'h0000_1240, 1'b0);
    // R10: a request during the refill must be ignored
    repeat (5) @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 32'hDEAD_0040;
    repeat (3) @(negedge clk);
    miss_valid = 1'b0;
    drain();
    // back-to-back: second request held across completion
    issue(32'h00AB_CD00, 1'b1);
    issue(32'h7FFF_FFC0, 1'b0);
    drain();
    finished = 1'b1;
  end

endmodule

module refill_seq_bench;
  logic clk;
  logic rst;
  int   cyc;
  logic fin_n, fin_w, fin_i;
  int   chk_n, chk_w, chk_i, err_n, err_w, err_i;
  int   total_chk, total_err;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  refill_seq_harness #(.ORG(refill_pkg::ORG_NARROW), .PEN(177), .BEAT(1), .PTAG("R4"))
    u_narrow (.clk(clk), .rst(rst), .cyc(cyc), .finished(fin_n), .checks(chk_n), .errors(err_n));
  refill_seq_harness #(.ORG(refill_pkg::ORG_WIDE), .PEN(45), .BEAT(4), .PTAG("R5"))
    u_wide (.clk(clk), .rst(rst), .cyc(cyc), .finished(fin_w), .checks(chk_w), .errors(err_w));
  refill_seq_harness #(.ORG(refill_pkg::ORG_INTERLEAVED), .PEN(57), .BEAT(1), .PTAG("R6"))
    u_ilv (.clk(clk), .rst(rst), .cyc(cyc), .finished(fin_i), .checks(chk_i), .errors(err_i));

  initial begin
    cyc = 0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    while (!(fin_n && fin_w && fin_i) && cyc < 20000) @(negedge clk);
    total_chk = chk_n + chk_w + chk_i;
    total_err = err_n + err_w + err_i;
    if (!(fin_n && fin_w && fin_i)) begin
      total_chk++;
      total_err++;
      $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cyc, 20000);
    end
    $display("Simulation finished: %0d checks, %0d errors", total_chk, total_err);
    $finish;
  end

endmodule